// File: doc/BRIEF.md
# Serial DAC Write Receiver

This block is the digital front end of a 12-bit voltage-output converter. It takes write frames from a host over three wires: an active-low frame select, a serial clock and a serial data line. All three pins are brought into the system clock domain, and edges are detected there. Each frame is sixteen bits long. Its low twelve bits are the converter code, and the two bits above them choose a power mode. The host shifts the bits MSB first, and the receiver samples each one on a falling edge of the serial clock.

The frame takes effect on its sixteenth falling edge. The select line does not have to rise first. At that point the held code and mode are replaced, and a one-cycle strobe tells the analog side that a new value is ready. Once a frame has completed, the receiver does nothing more until the select line goes high. Only a later falling edge of select starts the next frame. If select rises before sixteen bits have arrived, the partial frame is dropped.

The controller has four states:
- ST_WAIT_HIGH: the reset state. It moves to ST_ARMED once select is seen high.
- ST_ARMED: moves to ST_SHIFT on a falling edge of select.
- ST_SHIFT: returns to ST_ARMED if select rises (abort). It moves to ST_DONE on the sixteenth serial-clock fall (commit).
- ST_DONE: ignores all serial-clock edges and returns to ST_ARMED when select rises.

Top module: `dac_write_rx`

## Requirements
- R1: After reset, the code output is 0, the mode output is 0 (normal operation) and the update strobe is low.
- R2: A frame starts only on a falling edge of the select line seen after select was high. Data bits are sampled on falling edges of the serial clock while select is low, most significant bit first.
- R3: When a frame commits, frame bits [11:0] become the code output and bits [13:12] become the mode output. Mode 00 is normal operation, and the other values are power-down variants. Bits [15:14] have no effect.
- R4: A frame commits on its sixteenth serial-clock fall whether or not select has risen. The update strobe is high for exactly one system-clock cycle per committed frame.
- R5: If select rises before the sixteenth fall, the code and mode outputs stay unchanged and no strobe is produced.
- R6: Serial-clock falls that arrive after the sixteenth, while select stays low, change nothing and produce no strobe.
- R7: After a commit, the next frame can start only after select has gone high and then fallen again.
- R8: The system clock runs at least four times faster than the serial clock. The outputs change at the third rising system-clock edge after the sixteenth serial-clock fall appears at the pins.
- R9: The code is straight binary from 0 to 4095. The ideal output voltage is the reference times the code divided by 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame select from the host |
| ser_clk_i | input | 1 | Serial clock from the host; data is sampled on its falling edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| code_o | output | 12 | Held converter code |
| pmode_o | output | 2 | Held power mode, 00 = normal operation |
| upd_o | output | 1 | One-cycle strobe for each committed frame |

## Verification
The receiver is driven with several kinds of frame:
- Single-bit codes at the top and at the bottom of the field show that the bit order is right.
- Frames that set the two ignored top bits show that those bits are dropped.
- Frames that carry non-zero modes and full-scale codes show that the field boundaries are right.
- Truncated frames separate an abort from a commit.
- Frames that keep select low, followed by further clock edges and a whole second frame with no new select fall, show the difference between real re-arming and re-arming on any clock activity.
- A cycle-level reference model runs alongside the design. It pins down when the strobe appears and when the outputs change, so a change in the synchronizer delay is also seen.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

    // controller states
    typedef enum logic [1:0] {
        ST_WAIT_HIGH = 2'd0,
        ST_ARMED     = 2'd1,
        ST_SHIFT     = 2'd2,
        ST_DONE      = 2'd3
    } rx_state_t;

    // positions of the pins in the synchronized bus
    localparam int PIN_DAT  = 0;
    localparam int PIN_CLK  = 1;
    localparam int PIN_SEL  = 2;
    localparam int PIN_CNT  = 3;

endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dac_rx_fsm.sv
module dac_rx_fsm
    import dac_rx_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CODE_BITS  = 12,
    parameter int MODE_BITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 sclk_i,
    input  logic                 dat_i,
    output logic                 commit_o,
    output logic [CODE_BITS-1:0] code_o,
    output logic [MODE_BITS-1:0] mode_o
);

    localparam int PAY_W = CODE_BITS + MODE_BITS;
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    rx_state_t        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [PAY_W-2:0] shreg;
    logic [PAY_W-1:0] payload;
    logic             sel_prev, sclk_prev;
    logic             sel_fall, sclk_fall, last_bit;

    assign sel_fall  = sel_prev & ~sel_i;
    assign sclk_fall = sclk_prev & ~sclk_i;
    assign last_bit  = (cnt == LAST_IDX);
    // the top frame bits drop out of the short shift register
    assign payload   = {shreg, dat_i};
    assign code_o    = payload[CODE_BITS-1:0];
    assign mode_o    = payload[PAY_W-1:CODE_BITS];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_HIGH;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_HIGH: if (sel_i) nxt = ST_ARMED;
            ST_ARMED:     if (sel_fall) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (sel_i)                     nxt = ST_ARMED;
                else if (sclk_fall && last_bit) nxt = ST_DONE;
            end
            ST_DONE:      if (sel_i) nxt = ST_ARMED;
            default:      nxt = ST_WAIT_HIGH;
        endcase
    end

    // outputs
    always_comb begin
        commit_o = 1'b0;
        unique case (state)
            ST_SHIFT: commit_o = !sel_i && sclk_fall && last_bit;
            default:  commit_o = 1'b0;
        endcase
    end

    // bit counter, shift register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            sel_prev  <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            sel_prev  <= sel_i;
            sclk_prev <= sclk_i;
            if (state == ST_ARMED) begin
                cnt <= '0;
            end else if (state == ST_SHIFT && !sel_i && sclk_fall) begin
                cnt   <= cnt + 1'b1;
                shreg <= payload[PAY_W-2:0];
            end
        end
    end

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && sel_fall) |=> (state == ST_SHIFT && cnt == '0));

    // R5
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sel_i) |=> (state == ST_ARMED));

    // R4
    commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (state == ST_DONE));

    // R7
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !sel_i) |=> (state == ST_DONE));

endmodule

// File: rtl/dac_rx_regs.sv
module dac_rx_regs #(
    parameter int CODE_BITS = 12,
    parameter int MODE_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_i,
    input  logic [CODE_BITS-1:0] code_i,
    input  logic [MODE_BITS-1:0] mode_i,
    output logic [CODE_BITS-1:0] code_o,
    output logic [MODE_BITS-1:0] mode_o,
    output logic                 upd_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            mode_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= commit_i;
            if (commit_i) begin
                code_o <= code_i;
                mode_o <= mode_i;
            end
        end
    end

    // R4
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(code_o) && $stable(mode_o)));

endmodule

// File: rtl/dac_write_rx.sv
module dac_write_rx
    import dac_rx_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int CODE_BITS   = 12,
    parameter int MODE_BITS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n_i,
    input  logic                 ser_clk_i,
    input  logic                 ser_dat_i,
    output logic [CODE_BITS-1:0] code_o,
    output logic [MODE_BITS-1:0] pmode_o,
    output logic                 upd_o
);

    logic [PIN_CNT-1:0] pins_raw, pins_sync;
    logic               commit;
    logic [CODE_BITS-1:0] code_next;
    logic [MODE_BITS-1:0] mode_next;

    assign pins_raw[PIN_DAT] = ser_dat_i;
    assign pins_raw[PIN_CLK] = ser_clk_i;
    assign pins_raw[PIN_SEL] = frame_n_i;

    dac_rx_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_sync)
    );

    dac_rx_fsm #(.FRAME_BITS(FRAME_BITS), .CODE_BITS(CODE_BITS), .MODE_BITS(MODE_BITS)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (pins_sync[PIN_SEL]),
        .sclk_i   (pins_sync[PIN_CLK]),
        .dat_i    (pins_sync[PIN_DAT]),
        .commit_o (commit),
        .code_o   (code_next),
        .mode_o   (mode_next)
    );

    dac_rx_regs #(.CODE_BITS(CODE_BITS), .MODE_BITS(MODE_BITS)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .code_i   (code_next),
        .mode_i   (mode_next),
        .code_o   (code_o),
        .mode_o   (pmode_o),
        .upd_o    (upd_o)
    );

endmodule

// File: tb/dac_write_rx_tb.sv
module dac_write_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;       // serial half period in system clocks
    localparam real VREF      = 3.3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdat = 1'b0;
    logic [11:0] code_o;
    logic [1:0]  pmode_o;
    logic        upd_o;

    int n_checks = 0;
    int n_err    = 0;
    int pulses   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_write_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n_i (frame_n),
        .ser_clk_i (sclk),
        .ser_dat_i (sdat),
        .code_o    (code_o),
        .pmode_o   (pmode_o),
        .upd_o     (upd_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int hq[$];
    int m_state, m_cnt, m_acc, m_code, m_mode, m_upd;
    bit model_on = 0;

    function automatic int at(int i);
        return (i < 0) ? 0 : hq[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hq.delete();
            m_state = 0; m_cnt = 0; m_acc = 0;
            m_code = 0; m_mode = 0; m_upd = 0;
            model_on = 0;
        end else begin
            int last, cur, prv;
            bit c_sel, c_fall, c_dat;
            hq.push_back({29'd0, frame_n, sclk, sdat});
            last   = hq.size() - 1;
            cur    = at(last - 2);           // two synchronizer stages
            prv    = at(last - 3);
            c_sel  = cur[2];
            c_dat  = cur[0];
            c_fall = prv[1] && !cur[1];
            m_upd  = 0;
            case (m_state)
                0: if (c_sel) m_state = 1;
                1: if (!c_sel) begin m_state = 2; m_cnt = 0; end
                2: begin
                    if (c_sel) m_state = 1;
                    else if (c_fall) begin
                        m_acc = ((m_acc << 1) | c_dat) & 16'hFFFF;
                        m_cnt++;
                        if (m_cnt == 16) begin
                            m_code  = m_acc & 12'hFFF;
                            m_mode  = (m_acc >> 12) & 3;
                            m_upd   = 1;
                            m_state = 3;
                        end
                    end
                end
                default: if (c_sel) m_state = 1;
            endcase
            model_on = 1;
        end
    end

    always @(negedge clk) begin
        if (upd_o) pulses++;
        if (model_on) begin
            // R8 cycle-exact comparison against the model
            chk(code_o == 12'(m_code), "R8", "model code", int'(code_o), m_code);
            chk(pmode_o == 2'(m_mode), "R8", "model mode", int'(pmode_o), m_mode);
            chk(upd_o == 1'(m_upd), "R8", "model strobe", int'(upd_o), m_upd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_frame();
        frame_n = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int nbits, input bit chk_lat);
        for (int i = 0; i < nbits; i++) begin
            sdat = w[15 - i];
            wait_clks(HALF);
            sclk = 1'b0;
            if (chk_lat && i == nbits - 1) begin
                wait_clks(2);
                chk(upd_o == 1'b0, "R8", "strobe before third edge", int'(upd_o), 0);
                wait_clks(1);
                chk(upd_o == 1'b1, "R8", "strobe at third edge", int'(upd_o), 1);
                wait_clks(HALF - 3);
            end else begin
                wait_clks(HALF);
            end
            sclk = 1'b1;
        end
    endtask

    task automatic end_frame();
        wait_clks(HALF);
        frame_n = 1'b1;
        wait_clks(3 * HALF);
    endtask

    task automatic full_frame(input logic [15:0] w);
        start_frame();
        shift_bits(w, 16, 1'b0);
        end_frame();
    endtask

    task automatic check_out(input string req, input int exp_code, input int exp_mode);
        chk(code_o == 12'(exp_code), req, "code", int'(code_o), exp_code);
        chk(pmode_o == 2'(exp_mode), req, "mode", int'(pmode_o), exp_mode);
    endtask

    task automatic check_volts(input int exp_code);
        real v_dut, v_exp;
        v_dut = VREF * real'(code_o) / 4096.0;
        v_exp = VREF * real'(exp_code) / 4096.0;
        chk((v_dut - v_exp) < 1.0e-9 && (v_exp - v_dut) < 1.0e-9, "R9", "output mV",
            int'(v_dut * 1000.0), int'(v_exp * 1000.0));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int p0;
        wait_clks(5);
        // R1 reset state
        chk(code_o == 12'd0, "R1", "reset code", int'(code_o), 0);
        chk(pmode_o == 2'd0, "R1", "reset mode", int'(pmode_o), 0);
        chk(upd_o == 1'b0, "R1", "reset strobe", int'(upd_o), 0);
        rst_n = 1'b1;
        wait_clks(10);

        // R3 plain frame
        p0 = pulses;
        full_frame(16'h0ABC);
        check_out("R3", 12'hABC, 0);
        chk(pulses - p0 == 1, "R4", "one strobe per frame", pulses - p0, 1);

        // R2 MSB first, R3 top bits ignored
        full_frame(16'hC800);
        check_out("R2", 12'h800, 0);
        full_frame(16'h0001);
        check_out("R2", 12'h001, 0);

        // R3 mode field and R9 full scale
        full_frame(16'h2FFF);
        check_out("R3", 12'hFFF, 2);
        check_volts(12'hFFF);

        // R5 truncated frame is discarded
        p0 = pulses;
        start_frame();
        shift_bits(16'h1555, 9, 1'b0);
        end_frame();
        check_out("R5", 12'hFFF, 2);
        chk(pulses == p0, "R5", "no strobe on abort", pulses - p0, 0);

        // R6 extra edges while select stays low
        p0 = pulses;
        start_frame();
        shift_bits(16'h1123, 16, 1'b0);
        shift_bits(16'hFFFF, 5, 1'b0);
        check_out("R6", 12'h123, 1);
        chk(pulses - p0 == 1, "R6", "no strobe on extra edges", pulses - p0, 1);
        // R7 a whole frame without a new select fall has no effect
        shift_bits(16'h0456, 16, 1'b0);
        check_out("R7", 12'h123, 1);
        chk(pulses - p0 == 1, "R7", "no strobe without rearm", pulses - p0, 1);
        end_frame();
        full_frame(16'h0456);
        check_out("R7", 12'h456, 0);

        // R4 commit with select still low, R8 latency
        p0 = pulses;
        start_frame();
        shift_bits(16'h3000, 16, 1'b1);
        wait_clks(2);
        check_out("R4", 12'h000, 3);
        chk(pulses - p0 == 1, "R4", "strobe with select low", pulses - p0, 1);
        end_frame();

        // R9 zero code back in normal mode
        full_frame(16'h0000);
        check_out("R9", 0, 0);
        check_volts(0);

        wait_clks(10);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule